// File: doc/BRIEF.md
# Cascadable Up/Down Pulse Counter

A 16-bit pulse counter that advances once per rising edge on its count input `s0_i`, all sampled in the `clk_i` domain. The direction is taken from the level on `s1_i` when two control bits both allow it, and is up otherwise. The counter runs between 0 and a programmable limit. Each time it wraps, in either direction, it gives a single-cycle event pulse. It also presents the direction it used last as a level.

Two instances form a 32-bit counter. The event pulse of the low half drives the count input of the high half, and the low half's direction level drives the high half's direction input. The high half then moves by one in the same direction whenever the low half wraps. Writes to the control and limit registers reach the counting logic only after pulses arrive on the count input. A busy flag stays up until they have landed. A software reset-enable holds the counter at zero. While it is held, the limit can be loaded at once from a buffer register.

Top module: `pulse_cnt16`

## Requirements
- R1: After `rst_ni` is released, `cnt_o` is 0, `busy_o`, `ufof_o` and `dir_o` are 0, direction control is off and the limit is 0xFFFF.
- R2: Writing control with bit 0 (reset-enable) set stops the counter at once. The count reads 0 from the second cycle after the write, and count pulses have no effect while it is held.
- R3: A write to the limit (address 1), or a control write that changes bit 1 or bit 2, raises `busy_o` in the cycle after the write. `busy_o` falls only with the third following count pulse, which applies the new value.
- R4: Clearing reset-enable during a hold takes two count pulses. Neither of them moves the count, `busy_o` is high until the second one, and the third pulse counts.
- R5: While the hold is active and control bit 3 (immediate-load) is set, the limit follows the buffer register (address 2) with no count pulses needed. Without bit 3, the hold clears the limit to 0.
- R6: Writing the buffer register when no hold is active leaves the limit unchanged.
- R7: Counting up, the count steps by 1 and goes from the limit to 0. The wrap raises `ufof_o` for exactly one cycle.
- R8: Counting down, the count steps by 1 and goes from 0 to the limit, raising `ufof_o` for one cycle.
- R9: The count goes down only when control bits 1 (take direction from `s1_i`) and 2 (direction enable) are both active and `s1_i` is 1. With one bit alone it counts up. `dir_o` is 1 after a down pulse and 0 after an up pulse.
- R10: Two instances with the low `ufof_o` driving the high `s0_i`, and the low `dir_o` driving the high `s1_i`, behave as one 32-bit up/down counter `{high, low}` that wraps modulo 2^32.
- R11: A limit written through address 1 takes effect on the count pulse that clears `busy_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Register and sampling clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | 0 control, 1 limit, 2 limit buffer |
| wr_data_i | input | 16 | Write data; control uses bits 3:0 |
| s0_i | input | 1 | Count input, counted on rising edge |
| s1_i | input | 1 | Direction input, 1 means down |
| cnt_o | output | 16 | Current count |
| busy_o | output | 1 | Register writes still waiting for count pulses |
| ufof_o | output | 1 | One-cycle pulse on wrap |
| dir_o | output | 1 | Direction of the last count pulse |

## Verification
The assertions assume that `s0_i` is synchronous to `clk_i` and low for at least one cycle between pulses. They also assume that register writes never fall in the same cycle as a count edge. The bench drives every count pulse for whole clock cycles from the falling edge and issues writes only between pulses. It holds `s1_i` steady across each pulse. In the cascade, the only source of a high-half pulse that is not a bench-driven pulse is the low half's one-cycle event.

// File: rtl/pulse_cnt_pkg.sv
package pulse_cnt_pkg;
  typedef enum logic [1:0] {
    ADDR_CTRL = 2'd0,
    ADDR_TOP  = 2'd1,
    ADDR_TOPB = 2'd2
  } reg_addr_e;

  localparam int CTRL_W = 4;

  typedef struct packed {
    logic imm_load;
    logic dir_en;
    logic s1_sel;
    logic rst_en;
  } ctrl_t;
endpackage

// File: rtl/pulse_cnt_regs.sv
module pulse_cnt_regs
  import pulse_cnt_pkg::*;
#(
  parameter int               WIDTH      = 16,
  parameter int               SYNC_TICKS = 3,
  parameter int               REL_TICKS  = 2,
  parameter logic [WIDTH-1:0] TOP_RST    = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_addr_i,
  input  logic [WIDTH-1:0] wr_data_i,
  input  logic             tick_i,
  output logic             hold_o,
  output logic             s1_sel_o,
  output logic             dir_en_o,
  output logic             imm_o,
  output logic [WIDTH-1:0] top_o,
  output logic [WIDTH-1:0] topb_o,
  output logic             busy_o
);
  localparam int SW = $clog2(SYNC_TICKS + 1);
  localparam int RW = $clog2(REL_TICKS + 1);

  ctrl_t            wctrl;
  logic             wr_ctrl, wr_top, wr_topb, ctrl_chg, wr_sync, pend_any, apply;
  logic             hold_q, imm_q, s1_sel_q, dir_en_q;
  logic             pend_s1, pend_den, pend_ctrl_v, pend_top_v;
  logic [WIDTH-1:0] pend_top, top_q, topb_q;
  logic [SW-1:0]    sync_cnt;
  logic [RW-1:0]    rel_cnt;
  logic             unused_data;

  assign wctrl       = ctrl_t'(wr_data_i[CTRL_W-1:0]);
  assign unused_data = ^wr_data_i[WIDTH-1:CTRL_W];
  assign wr_ctrl     = wr_en_i && (wr_addr_i == ADDR_CTRL);
  assign wr_top      = wr_en_i && (wr_addr_i == ADDR_TOP);
  assign wr_topb     = wr_en_i && (wr_addr_i == ADDR_TOPB);
  // only a change of the direction bits needs to cross into the count domain
  assign ctrl_chg    = (wctrl.s1_sel != s1_sel_q) || (wctrl.dir_en != dir_en_q);
  assign wr_sync     = (wr_ctrl && ctrl_chg) || wr_top;
  assign pend_any    = pend_ctrl_v || pend_top_v;
  assign apply       = tick_i && pend_any && !wr_sync && (sync_cnt == SW'(SYNC_TICKS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q      <= 1'b0;
      rel_cnt     <= '0;
      imm_q       <= 1'b0;
      s1_sel_q    <= 1'b0;
      dir_en_q    <= 1'b0;
      pend_s1     <= 1'b0;
      pend_den    <= 1'b0;
      pend_ctrl_v <= 1'b0;
      pend_top    <= '0;
      pend_top_v  <= 1'b0;
      top_q       <= TOP_RST;
      topb_q      <= TOP_RST;
      sync_cnt    <= '0;
    end else begin
      // reset-enable: set at once, release after REL_TICKS count pulses
      if (wr_ctrl) begin
        imm_q <= wctrl.imm_load;
        if (wctrl.rst_en) begin
          hold_q  <= 1'b1;
          rel_cnt <= '0;
        end else if (hold_q) begin
          rel_cnt <= RW'(REL_TICKS);
        end
      end else if (tick_i && rel_cnt != '0) begin
        rel_cnt <= rel_cnt - RW'(1);
        if (rel_cnt == RW'(1)) hold_q <= 1'b0;
      end

      if (wr_ctrl && ctrl_chg) begin
        pend_s1     <= wctrl.s1_sel;
        pend_den    <= wctrl.dir_en;
        pend_ctrl_v <= 1'b1;
      end else if (apply) begin
        pend_ctrl_v <= 1'b0;
        if (pend_ctrl_v) begin
          s1_sel_q <= pend_s1;
          dir_en_q <= pend_den;
        end
      end

      if (wr_top) begin
        pend_top   <= wr_data_i;
        pend_top_v <= 1'b1;
      end else if (apply) begin
        pend_top_v <= 1'b0;
      end

      if (wr_topb) topb_q <= wr_data_i;

      if (wr_sync || apply)         sync_cnt <= '0;
      else if (tick_i && pend_any)  sync_cnt <= sync_cnt + SW'(1);

      if (hold_q)                   top_q <= imm_q ? topb_q : '0;
      else if (apply && pend_top_v) top_q <= pend_top;
    end
  end

  assign hold_o   = hold_q;
  assign s1_sel_o = s1_sel_q;
  assign dir_en_o = dir_en_q;
  assign imm_o    = imm_q;
  assign top_o    = top_q;
  assign topb_o   = topb_q;
  assign busy_o   = pend_any || (rel_cnt != '0);
endmodule

// File: rtl/pulse_cnt_core.sv
module pulse_cnt_core #(
  parameter int WIDTH = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             hold_i,
  input  logic             down_i,
  input  logic [WIDTH-1:0] top_i,
  output logic [WIDTH-1:0] cnt_o,
  output logic             wrap_o,
  output logic             dir_o
);
  logic [WIDTH-1:0] cnt_q;
  logic             wrap_q, dir_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      wrap_q <= 1'b0;
      dir_q  <= 1'b0;
    end else if (hold_i) begin
      cnt_q  <= '0;
      wrap_q <= 1'b0;
      dir_q  <= 1'b0;
    end else begin
      wrap_q <= 1'b0;
      if (tick_i) begin
        dir_q <= down_i;
        if (down_i) begin
          if (cnt_q == '0) begin
            cnt_q  <= top_i;
            wrap_q <= 1'b1;
          end else begin
            cnt_q <= cnt_q - WIDTH'(1);
          end
        end else if (cnt_q == top_i) begin
          cnt_q  <= '0;
          wrap_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + WIDTH'(1);
        end
      end
    end
  end

  assign cnt_o  = cnt_q;
  assign wrap_o = wrap_q;
  assign dir_o  = dir_q;
endmodule

// File: rtl/pulse_cnt16.sv
module pulse_cnt16 #(
  parameter int WIDTH = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_addr_i,
  input  logic [WIDTH-1:0] wr_data_i,
  input  logic             s0_i,
  input  logic             s1_i,
  output logic [WIDTH-1:0] cnt_o,
  output logic             busy_o,
  output logic             ufof_o,
  output logic             dir_o
);
  logic             s0_q, tick, down;
  logic             hold, s1_sel, dir_en, imm;
  logic [WIDTH-1:0] top, topb;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) s0_q <= 1'b0;
    else         s0_q <= s0_i;
  end

  assign tick = s0_i && !s0_q;
  assign down = s1_sel && dir_en && s1_i;

  pulse_cnt_regs #(.WIDTH(WIDTH)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .tick_i    (tick),
    .hold_o    (hold),
    .s1_sel_o  (s1_sel),
    .dir_en_o  (dir_en),
    .imm_o     (imm),
    .top_o     (top),
    .topb_o    (topb),
    .busy_o    (busy_o)
  );

  pulse_cnt_core #(.WIDTH(WIDTH)) u_core (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick),
    .hold_i (hold),
    .down_i (down),
    .top_i  (top),
    .cnt_o  (cnt_o),
    .wrap_o (ufof_o),
    .dir_o  (dir_o)
  );
endmodule

// File: rtl/pulse_cnt16_chk.sv
module pulse_cnt16_chk #(
  parameter int WIDTH = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tick,
  input logic             hold,
  input logic             down,
  input logic             wr_en,
  input logic             imm,
  input logic [WIDTH-1:0] top,
  input logic [WIDTH-1:0] topb,
  input logic [WIDTH-1:0] cnt,
  input logic             busy,
  input logic             ufof
);
  a_r2_hold_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold |=> (cnt == '0) && !ufof);

  a_r3_busy_needs_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy && !tick && !wr_en |=> busy);

  a_r5_imm_follows_buf: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold && imm && !wr_en |=> top == $past(topb));

  a_r7_up_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick && !hold && !down && (cnt != top) |=> cnt == WIDTH'($past(cnt) + 1));

  a_r7_wrap_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ufof |=> !ufof);

  a_r8_down_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick && !hold && down && (cnt == '0) |=> (cnt == $past(top)) && ufof);
endmodule

bind pulse_cnt16 pulse_cnt16_chk #(.WIDTH(WIDTH)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .tick   (tick),
  .hold   (hold),
  .down   (down),
  .wr_en  (wr_en_i),
  .imm    (imm),
  .top    (top),
  .topb   (topb),
  .cnt    (cnt_o),
  .busy   (busy_o),
  .ufof   (ufof_o)
);

// File: tb/pulse_cnt16_tb_top.sv
module pulse_cnt16_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  int checks = 0;
  int errors = 0;

  // single instance
  logic        s_we = 1'b0, s_s0 = 1'b0, s_s1 = 1'b0;
  logic [1:0]  s_wa = '0;
  logic [15:0] s_wd = '0, s_cnt;
  logic        s_busy, s_uf, s_dir;

  pulse_cnt16 dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(s_we), .wr_addr_i(s_wa), .wr_data_i(s_wd),
    .s0_i(s_s0), .s1_i(s_s1), .cnt_o(s_cnt), .busy_o(s_busy), .ufof_o(s_uf), .dir_o(s_dir)
  );

  // cascaded pair
  logic        l_we = 1'b0, l_s0 = 1'b0, l_s1 = 1'b0;
  logic        h_we = 1'b0, h_sw = 1'b0;
  logic [1:0]  l_wa = '0, h_wa = '0;
  logic [15:0] l_wd = '0, h_wd = '0, l_cnt, h_cnt;
  logic        l_busy, l_uf, l_dir, h_busy, h_uf, h_dir, h_s0;

  assign h_s0 = l_uf | h_sw;

  pulse_cnt16 lo_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(l_we), .wr_addr_i(l_wa), .wr_data_i(l_wd),
    .s0_i(l_s0), .s1_i(l_s1), .cnt_o(l_cnt), .busy_o(l_busy), .ufof_o(l_uf), .dir_o(l_dir)
  );

  pulse_cnt16 hi_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(h_we), .wr_addr_i(h_wa), .wr_data_i(h_wd),
    .s0_i(h_s0), .s1_i(l_dir), .cnt_o(h_cnt), .busy_o(h_busy), .ufof_o(h_uf), .dir_o(h_dir)
  );

  logic [31:0] model;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic s_write(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); s_we = 1'b1; s_wa = a; s_wd = d;
    @(negedge clk); s_we = 1'b0;
  endtask

  task automatic l_write(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); l_we = 1'b1; l_wa = a; l_wd = d;
    @(negedge clk); l_we = 1'b0;
  endtask

  task automatic h_write(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); h_we = 1'b1; h_wa = a; h_wd = d;
    @(negedge clk); h_we = 1'b0;
  endtask

  // rising edge; returns one cycle after the counting edge
  task automatic s_rise();
    @(negedge clk); s_s0 = 1'b1;
    @(negedge clk);
  endtask

  task automatic s_fall();
    s_s0 = 1'b0;
    @(negedge clk);
  endtask

  task automatic s_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      s_rise();
      s_fall();
    end
  endtask

  task automatic h_tick();
    @(negedge clk); h_sw = 1'b1;
    @(negedge clk); h_sw = 1'b0;
    @(negedge clk);
  endtask

  // low pulse, then one more cycle for the high half to follow
  task automatic l_tick();
    @(negedge clk); l_s0 = 1'b1;
    @(negedge clk);
    @(negedge clk); l_s0 = 1'b0;
    @(negedge clk);
  endtask

  task automatic casc_run(input logic dn, input int n);
    l_s1 = dn;
    for (int i = 0; i < n; i++) begin
      l_tick();
      model = dn ? model - 32'd1 : model + 32'd1;
      check("R10 cascade 32-bit count", {h_cnt, l_cnt}, model);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 cnt", {16'd0, s_cnt}, 32'd0);
    check("R1 busy", {31'd0, s_busy}, 32'd0);
    check("R1 ufof", {31'd0, s_uf}, 32'd0);
    check("R1 dir", {31'd0, s_dir}, 32'd0);

    s_ticks(3);
    check("R7 up step", {16'd0, s_cnt}, 32'd3);

    // R3 / R11 limit write crosses on third pulse
    s_write(2'd1, 16'd9);
    check("R3 busy after write", {31'd0, s_busy}, 32'd1);
    s_ticks(2);
    check("R3 busy before third pulse", {31'd0, s_busy}, 32'd1);
    check("R3 count during sync", {16'd0, s_cnt}, 32'd5);
    s_ticks(1);
    check("R3 busy cleared", {31'd0, s_busy}, 32'd0);
    s_ticks(3);
    check("R11 count at new limit", {16'd0, s_cnt}, 32'd9);
    s_rise();
    check("R7 up wrap to zero", {16'd0, s_cnt}, 32'd0);
    check("R7 wrap pulse", {31'd0, s_uf}, 32'd1);
    s_fall();
    check("R7 wrap pulse one cycle", {31'd0, s_uf}, 32'd0);

    // R9 direction control
    s_s1 = 1'b1;
    s_write(2'd0, 16'h0002);
    s_ticks(4);
    check("R9 one bit alone counts up", {16'd0, s_cnt}, 32'd4);
    check("R9 dir up", {31'd0, s_dir}, 32'd0);
    s_write(2'd0, 16'h0006);
    s_ticks(3);
    check("R9 old direction until synced", {16'd0, s_cnt}, 32'd7);
    s_ticks(1);
    check("R9 counts down", {16'd0, s_cnt}, 32'd6);
    check("R9 dir down", {31'd0, s_dir}, 32'd1);
    s_ticks(6);
    check("R8 down to zero", {16'd0, s_cnt}, 32'd0);
    s_rise();
    check("R8 down wrap to limit", {16'd0, s_cnt}, 32'd9);
    check("R8 wrap pulse", {31'd0, s_uf}, 32'd1);
    s_fall();
    check("R8 wrap pulse one cycle", {31'd0, s_uf}, 32'd0);

    // R2 hold
    s_write(2'd0, 16'h0007);
    @(negedge clk);
    check("R2 count cleared", {16'd0, s_cnt}, 32'd0);
    s_ticks(3);
    check("R2 pulses ignored", {16'd0, s_cnt}, 32'd0);

    // R5 immediate load, R4 release
    s_write(2'd2, 16'h1234);
    s_write(2'd0, 16'h000F);
    s_ticks(1);
    s_write(2'd0, 16'h000E);
    check("R4 busy during release", {31'd0, s_busy}, 32'd1);
    s_ticks(1);
    check("R4 first release pulse", {16'd0, s_cnt}, 32'd0);
    check("R4 busy after first pulse", {31'd0, s_busy}, 32'd1);
    s_ticks(1);
    check("R4 second release pulse", {16'd0, s_cnt}, 32'd0);
    check("R4 busy cleared", {31'd0, s_busy}, 32'd0);
    s_rise();
    check("R5 limit loaded from buffer", {16'd0, s_cnt}, 32'h1234);
    s_fall();

    // R6 buffer write outside hold
    s_write(2'd2, 16'h0042);
    s_ticks(1);
    check("R6 down step", {16'd0, s_cnt}, 32'h1233);
    s_s1 = 1'b0;
    s_ticks(1);
    check("R6 up to old limit", {16'd0, s_cnt}, 32'h1234);
    s_rise();
    check("R6 limit unchanged", {16'd0, s_cnt}, 32'd0);
    check("R6 wrap at old limit", {31'd0, s_uf}, 32'd1);
    s_fall();

    // cascade setup
    l_write(2'd0, 16'h0006);
    repeat (3) l_tick();
    l_write(2'd2, 16'hFFFF);
    l_write(2'd0, 16'h000F);
    h_write(2'd2, 16'hFFFF);
    h_write(2'd0, 16'h000F);
    repeat (3) h_tick();
    check("R3 high synced", {31'd0, h_busy}, 32'd0);
    h_write(2'd0, 16'h000E);
    repeat (2) h_tick();
    check("R4 high released", {31'd0, h_busy}, 32'd0);
    l_write(2'd0, 16'h000E);
    repeat (2) l_tick();
    check("R4 low released", {31'd0, l_busy}, 32'd0);
    check("R10 cascade start", {h_cnt, l_cnt}, 32'd0);

    model = 32'd0;
    casc_run(1'b1, 1);
    casc_run(1'b0, 1);
    casc_run(1'b0, 5);
    casc_run(1'b1, 7);
    casc_run(1'b0, 2);
    casc_run(1'b1, 3);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule